// File: doc/BRIEF.md
# Serial Configuration Port with Volume and Control Registers

This block is a write-only, three-line serial configuration port. A host shifts 16-bit words in on a data line, most significant bit first, timed by a control clock. A separate latch line then commits the captured word. The two least significant bits of the word pick a destination: left volume, right volume or a control register. The upper 14 bits are the value written there.

All three lines are brought into the system clock domain through synchronizer chains, and edges are detected there, so the control clock may be gated or may run continuously. The control register holds the sample-rate selects, the right-justified word length, a soft reset, a soft mute, the serial data format and the de-emphasis curve. Several of these fields are combined by OR with hardware strap pins to give the effective configuration that the audio path uses. A hardware reset sets both volumes to full scale and clears the control register. A soft reset only drives an output level and leaves every register as it is.

Top module: `cfgp_top`

## Requirements
- R1: While `rst` is high at a clock edge, both volume registers become all ones (0x3FFF) and every control field becomes 0. With all pins low, every `cfg_*` output is then 0.
- R2: Each rising edge of `ctl_sclk` shifts `ctl_sdi` into a 16-bit register, most significant bit first. Only the last 16 bits before a commit count, and older bits fall off.
- R3: Registers change only on a rising edge of `ctl_latch`. Shifting bits without a latch edge leaves every output unchanged.
- R4: Word bits [1:0] select the destination: 00 is left volume, 10 is right volume, 01 is control. The register receives word bits [15:2].
- R5: A committed word with bits [1:0] = 11 changes no register.
- R6: Word bit 11 is the 2x rate select, and `cfg_rate2x` = bit 11 OR `pin_rate2x`. Word bit 10 is the 4x rate select, and `cfg_rate4x` = bit 10 OR `pin_rate4x`.
- R7: Word bits [9:8] drive `cfg_wordlen` directly: 00 means 24 bits, 01 means 20 bits, 10 means 16 bits.
- R8: Word bit 7 drives `cfg_soft_rst`. Writing it does not disturb the volume registers.
- R9: Word bit 6 is the soft mute, and `cfg_mute` = bit 6 OR `pin_mute`.
- R10: Word bits [5:4] select the format (00 right-justified, 01 I2S, 10 left-justified, 11 DSP), and `cfg_fmt` is their bitwise OR with `pin_fmt`.
- R11: Word bits [3:2] drive `cfg_deemph`: 00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz.
- R12: If a latch rising edge and a control-clock rising edge are detected in the same cycle, the commit uses the word as it was before that shift. The new bit still enters the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctl_sclk | input | 1 | Serial control clock (asynchronous) |
| ctl_sdi | input | 1 | Serial control data, most significant bit first |
| ctl_latch | input | 1 | Commit strobe; acts on its rising edge |
| pin_rate2x | input | 1 | Hardware strap for 2x rate select |
| pin_rate4x | input | 1 | Hardware strap for 4x rate select |
| pin_mute | input | 1 | Hardware mute |
| pin_fmt | input | 2 | Hardware strap for serial format |
| vol_left | output | 14 | Left volume word |
| vol_right | output | 14 | Right volume word |
| cfg_rate2x | output | 1 | Effective 2x rate select |
| cfg_rate4x | output | 1 | Effective 4x rate select |
| cfg_wordlen | output | 2 | Right-justified word length code |
| cfg_soft_rst | output | 1 | Soft reset level |
| cfg_mute | output | 1 | Effective mute |
| cfg_fmt | output | 2 | Effective serial format code |
| cfg_deemph | output | 2 | De-emphasis curve code |

## Verification
A shift and a commit can fall in the same cycle when the control clock keeps running while the latch rises. The bench provokes this by raising `ctl_latch` and `ctl_sclk` on the same clock with a known data bit. It then checks that the committed volume matches the earlier 16 bits. It also checks that the extra bit is still held: 15 more bits and a plain latch must yield a word whose top bit is that extra bit.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_VOL_L = 2'b00,
        SEL_CTRL  = 2'b01,
        SEL_VOL_R = 2'b10,
        SEL_NONE  = 2'b11
    } sel_e;

    // Field order follows word bits 11 down to 2.
    typedef struct packed {
        logic       rate2x;
        logic       rate4x;
        logic [1:0] wlen;
        logic       soft_rst;
        logic       mute;
        logic [1:0] fmt;
        logic [1:0] deemph;
    } ctl_t;

    localparam int CTL_W   = $bits(ctl_t);
    localparam int CTL_LSB = ADDR_W;

    function automatic sel_e sel_of(input logic [WORD_W-1:0] w);
        return sel_e'(w[ADDR_W-1:0]);
    endfunction

    function automatic logic [PAY_W-1:0] payload_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:ADDR_W];
    endfunction

    function automatic ctl_t ctl_of(input logic [WORD_W-1:0] w);
        return ctl_t'(w[CTL_LSB +: CTL_W]);
    endfunction

endpackage

// File: rtl/cfgp_sync_line.sv
module cfgp_sync_line #(
    parameter int STAGES      = 2,
    parameter bit DETECT_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    generate
        if (DETECT_EDGE) begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= 1'b0;
                else     prev <= chain[STAGES-1];
            end
            assign q = chain[STAGES-1] & ~prev;
        end else begin : g_level
            assign q = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cfgp_shift.sv
module cfgp_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [PAY_W-1:0]  vol_l,
    output logic [PAY_W-1:0]  vol_r,
    output ctl_t              ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_l <= '1;
            vol_r <= '1;
            ctl   <= '0;
        end else if (commit) begin
            case (sel_of(word))
                SEL_VOL_L: vol_l <= payload_of(word);
                SEL_VOL_R: vol_r <= payload_of(word);
                SEL_CTRL:  ctl   <= ctl_of(word);
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_sclk,
    input  logic             ctl_sdi,
    input  logic             ctl_latch,
    input  logic             pin_rate2x,
    input  logic             pin_rate4x,
    input  logic             pin_mute,
    input  logic [1:0]       pin_fmt,
    output logic [PAY_W-1:0] vol_left,
    output logic [PAY_W-1:0] vol_right,
    output logic             cfg_rate2x,
    output logic             cfg_rate4x,
    output logic [1:0]       cfg_wordlen,
    output logic             cfg_soft_rst,
    output logic             cfg_mute,
    output logic [1:0]       cfg_fmt,
    output logic [1:0]       cfg_deemph
);

    logic              sclk_rise;
    logic              latch_rise;
    logic              sdi_s;
    logic [WORD_W-1:0] shift_word;
    ctl_t              ctl_reg;

    cfgp_sync_line #(.STAGES(SYNC_STAGES), .DETECT_EDGE(1'b1)) u_sync_sclk (
        .clk(clk), .rst(rst), .din(ctl_sclk), .q(sclk_rise)
    );
    cfgp_sync_line #(.STAGES(SYNC_STAGES), .DETECT_EDGE(1'b1)) u_sync_latch (
        .clk(clk), .rst(rst), .din(ctl_latch), .q(latch_rise)
    );
    cfgp_sync_line #(.STAGES(SYNC_STAGES), .DETECT_EDGE(1'b0)) u_sync_sdi (
        .clk(clk), .rst(rst), .din(ctl_sdi), .q(sdi_s)
    );

    cfgp_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(sclk_rise), .bit_in(sdi_s), .word(shift_word)
    );

    cfgp_bank u_bank (
        .clk(clk), .rst(rst), .commit(latch_rise), .word(shift_word),
        .vol_l(vol_left), .vol_r(vol_right), .ctl(ctl_reg)
    );

    always_comb begin
        cfg_rate2x   = ctl_reg.rate2x | pin_rate2x;
        cfg_rate4x   = ctl_reg.rate4x | pin_rate4x;
        cfg_wordlen  = ctl_reg.wlen;
        cfg_soft_rst = ctl_reg.soft_rst;
        cfg_mute     = ctl_reg.mute | pin_mute;
        cfg_fmt      = ctl_reg.fmt | pin_fmt;
        cfg_deemph   = ctl_reg.deemph;
    end

endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk
    import cfgp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              commit,
    input logic [WORD_W-1:0] word,
    input logic [PAY_W-1:0]  vol_l,
    input logic [PAY_W-1:0]  vol_r,
    input logic [CTL_W-1:0]  ctl
);

    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        rst |=> (vol_l == '1 && vol_r == '1 && ctl == '0));

    // R3
    hold_without_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(vol_l) && $stable(vol_r) && $stable(ctl)));

    // R4
    left_write_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && word[1:0] == 2'b00) |=> (vol_l == $past(word[WORD_W-1:ADDR_W]) && $stable(vol_r)));

    // R4
    right_write_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && word[1:0] == 2'b10) |=> (vol_r == $past(word[WORD_W-1:ADDR_W]) && $stable(vol_l)));

    // R5
    unused_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && word[1:0] == 2'b11) |=> ($stable(vol_l) && $stable(vol_r) && $stable(ctl)));

    // R8
    ctrl_keeps_vol_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && word[1:0] == 2'b01) |=> ($stable(vol_l) && $stable(vol_r)));

endmodule

bind cfgp_top cfgp_chk u_chk (
    .clk(clk), .rst(rst), .commit(latch_rise), .word(shift_word),
    .vol_l(vol_left), .vol_r(vol_right), .ctl(ctl_reg)
);

// File: tb/cfgp_top_tb.sv
module cfgp_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, sdi = 1'b0, latch = 1'b0;
    logic        p2x = 1'b0, p4x = 1'b0, pmute = 1'b0;
    logic [1:0]  pfmt = 2'b00;
    logic [13:0] vl, vr;
    logic        r2x, r4x, srst, mute;
    logic [1:0]  wlen, fmt, deemph;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfgp_top u_dut (
        .clk(clk), .rst(rst), .ctl_sclk(sclk), .ctl_sdi(sdi), .ctl_latch(latch),
        .pin_rate2x(p2x), .pin_rate4x(p4x), .pin_mute(pmute), .pin_fmt(pfmt),
        .vol_left(vl), .vol_right(vr), .cfg_rate2x(r2x), .cfg_rate4x(r4x),
        .cfg_wordlen(wlen), .cfg_soft_rst(srst), .cfg_mute(mute),
        .cfg_fmt(fmt), .cfg_deemph(deemph)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sdi = w[i];
            wait_n(4); sclk = 1'b1;
            wait_n(4); sclk = 1'b0;
        end
    endtask

    task automatic pulse_latch();
        @(negedge clk); latch = 1'b1;
        wait_n(4); latch = 1'b0;
        wait_n(4);
    endtask

    task automatic write_word(input logic [15:0] w);
        send_bits({16'h0, w}, 16);
        pulse_latch();
    endtask

    task automatic t_reset();
        check("R1 vol_left", vl, 14'h3FFF);
        check("R1 vol_right", vr, 14'h3FFF);
        check("R1 cfg all", {r2x, r4x, wlen, srst, mute, fmt, deemph}, 0);
    endtask

    task automatic t_volumes();
        write_word(16'h1234);
        check("R4 R2 left write", vl, 14'h048D);
        check("R4 right untouched", vr, 14'h3FFF);
        write_word(16'hF0F2);
        check("R4 right write", vr, 14'h3C3C);
        check("R4 left untouched", vl, 14'h048D);
    endtask

    task automatic t_no_latch();
        send_bits(32'h0000_5550, 16);
        wait_n(6);
        check("R3 no commit left", vl, 14'h048D);
        check("R3 no commit right", vr, 14'h3C3C);
        pulse_latch();
        check("R3 latch commits", vl, 14'h1554);
    endtask

    task automatic t_long_word();
        // 20 bits: 4 leading bits must fall off
        send_bits(32'h000F_2AAA, 20);
        pulse_latch();
        check("R2 last 16 bits", vr, 14'h0AAA);
    endtask

    task automatic t_unused_sel();
        write_word(16'hFFFF);
        check("R5 left kept", vl, 14'h1554);
        check("R5 right kept", vr, 14'h0AAA);
        check("R5 ctrl kept", {r2x, r4x, wlen, srst, mute, fmt, deemph}, 0);
    endtask

    task automatic t_control();
        write_word(16'h021D);
        check("R7 wordlen 16", wlen, 2'b10);
        check("R10 fmt i2s", fmt, 2'b01);
        check("R11 deemph 48k", deemph, 2'b11);
        check("R9 mute off", mute, 1'b0);
        pmute = 1'b1; pfmt = 2'b10; p2x = 1'b1;
        wait_n(1);
        check("R9 pin mute", mute, 1'b1);
        check("R10 fmt or pins", fmt, 2'b11);
        check("R6 pin 2x", r2x, 1'b1);
        pmute = 1'b0; pfmt = 2'b00; p2x = 1'b0;
        write_word(16'h08C1);
        check("R8 soft reset", srst, 1'b1);
        check("R8 volumes kept", {vl, vr}, {14'h1554, 14'h0AAA});
        check("R6 bit11 2x", r2x, 1'b1);
        check("R9 soft mute", mute, 1'b1);
        check("R6 4x off", r4x, 1'b0);
        write_word(16'h0401);
        check("R6 bit10 4x", {r4x, r2x, srst}, 3'b100);
        p4x = 1'b1;
        write_word(16'h0001);
        check("R6 pin 4x", r4x, 1'b1);
        p4x = 1'b0;
    endtask

    task automatic t_coincident();
        send_bits(32'h0000_1234, 16);
        @(negedge clk); sdi = 1'b1; sclk = 1'b1; latch = 1'b1;
        wait_n(4); sclk = 1'b0; latch = 1'b0;
        wait_n(4);
        check("R12 commit pre-shift word", vl, 14'h048D);
        send_bits(32'h0000_256A, 15);
        pulse_latch();
        check("R12 extra bit kept", vr, 14'h295A);
    endtask

    task automatic t_hw_reset();
        @(negedge clk); rst = 1'b1;
        wait_n(2); rst = 1'b0;
        wait_n(1);
        check("R1 rerun vol", {vl, vr}, {14'h3FFF, 14'h3FFF});
        check("R1 rerun ctrl", {r2x, r4x, wlen, srst, mute, fmt, deemph}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_volumes();
        t_no_latch();
        t_long_word();
        t_unused_sel();
        t_control();
        t_coincident();
        t_hw_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule